// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned 32-bit numbers by repeated subtraction. Two working registers hold the pair. On every step the larger value is reduced by the smaller one, or the pair is exchanged when the first value is the smaller. The work stops when the second register reaches zero, and the first register then holds the answer.

The less-than decision comes from the borrow bit of a subtractor that is one bit wider than the operands. No separate comparator is used. The less-than and second-is-zero flags are stored in registers before the sequencer reads them. Because of this, each step spends one cycle letting the flags settle into their registers and a second cycle applying the chosen update.

A caller waits for `idle_o`, then pulses `start_i` with both operands. When `done_o` rises, the caller reads `gcd_o` and acknowledges it with `ack_i`.

Top module: `gcd_sub`

## Requirements
- R1: During and after reset, `idle_o` is 1, `done_o` is 0 and `gcd_o` reads 0.
- R2: If `start_i` is high at a clock edge while `idle_o` is 1, `opa_i` and `opb_i` are captured. The block later raises `done_o` with `gcd_o` equal to the greatest common divisor of the two operands.
- R3: If both operands are zero the result is 0. If exactly one operand is zero the result is the other operand.
- R4: While `done_o` is high and `ack_i` is low, `done_o` stays high and `gcd_o` does not change. If `ack_i` is high at an edge while `done_o` is high, the next cycle shows `idle_o` = 1 and `done_o` = 0.
- R5: `start_i` has no effect unless `idle_o` is 1. This holds during computation, and also in the result-pending state when `ack_i` arrives in the same cycle.
- R6: Each step takes exactly two cycles. One step does one of three things: it ends when the second value is zero, it exchanges the pair when the first value is smaller, or it otherwise replaces the first value with the difference. With n steps including the final zero test, `done_o` is first high 2n clock edges after the edge that captured the operands.
- R7: The less-than decision is correct over the full unsigned range. This includes pairs where the top bit of the 32-bit difference would give the wrong answer, such as C0000000h/20000000h and 10000000h/A0000000h.
- R8: `idle_o` and `done_o` are never high together. `idle_o` stays low from the capturing edge until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to capture the operands |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| ack_i | input | 1 | Acknowledge of the presented result |
| idle_o | output | 1 | Ready to accept a start |
| done_o | output | 1 | Result valid |
| gcd_o | output | 32 | Result value (first working register) |

## Verification
Two events can fall in the same cycle: the caller acknowledging a finished result and a new start request. The bench drives `ack_i` and `start_i` high together while `done_o` is high. It then checks that the block is idle on the next cycle rather than busy, which shows the start was dropped. A second start pulse issued mid-computation with different operands must leave the original result untouched. The completion cycle is also judged against a step count computed from the operand pair, so a sequencer that acts on stale flags shows up as a latency mismatch.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    parameter int unsigned GCD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } gcd_state_e;

    typedef struct packed {
        gcd_state_e st;
        logic       apply;
    } gcd_ctrl_s;

    typedef struct packed {
        logic ld_in;
        logic x_en;
        logic y_en;
        logic x_sel;
    } gcd_cmd_s;

endpackage

// File: rtl/gcd_dpath.sv
module gcd_dpath #(
    parameter int unsigned W = gcd_pkg::GCD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  gcd_pkg::gcd_cmd_s cmd,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] x_val,
    output logic [W-1:0] y_val,
    output logic         lt_raw,
    output logic         yz_raw
);
    localparam int unsigned DW = W + 1;

    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
    } regs_s;

    regs_s          r_d, r_q;
    logic [DW-1:0]  diff;
    logic [W-1:0]   x_next;

    always_comb begin
        diff   = {1'b0, r_q.x} - {1'b0, r_q.y};
        x_next = cmd.x_sel ? r_q.y : diff[W-1:0];
        r_d    = r_q;
        if (cmd.ld_in) begin
            r_d.x = opa;
            r_d.y = opb;
        end else begin
            if (cmd.x_en) r_d.x = x_next;
            if (cmd.y_en) r_d.y = r_q.x;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign x_val  = r_q.x;
    assign y_val  = r_q.y;
    assign lt_raw = diff[DW-1];
    assign yz_raw = (r_q.y == '0);
endmodule

// File: rtl/gcd_flags.sv
module gcd_flags #(
    parameter int unsigned NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] flag_in,
    output logic [NF-1:0] flag_out
);
    logic [NF-1:0] f_d, f_q;

    for (genvar g = 0; g < NF; g++) begin : g_stage
        always_comb f_d[g] = flag_in[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flag_out = f_q;
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ack,
    input  logic              lt_q,
    input  logic              yz_q,
    output gcd_pkg::gcd_cmd_s cmd,
    output logic              idle,
    output logic              done
);
    import gcd_pkg::*;

    gcd_ctrl_s c_d, c_q;

    always_comb begin
        c_d  = c_q;
        cmd  = '0;
        idle = 1'b0;
        done = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                idle = 1'b1;
                if (start) begin
                    cmd.ld_in = 1'b1;
                    c_d.st    = ST_CALC;
                    c_d.apply = 1'b0;
                end
            end
            ST_CALC: begin
                if (!c_q.apply) begin
                    c_d.apply = 1'b1;
                end else begin
                    c_d.apply = 1'b0;
                    if (yz_q) begin
                        c_d.st = ST_DONE;
                    end else if (lt_q) begin
                        cmd.x_en  = 1'b1;
                        cmd.y_en  = 1'b1;
                        cmd.x_sel = 1'b1;
                    end else begin
                        cmd.x_en  = 1'b1;
                        cmd.x_sel = 1'b0;
                    end
                end
            end
            ST_DONE: begin
                done = 1'b1;
                if (ack) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, apply: 1'b0};
        else        c_q <= c_d;
    end
endmodule

// File: rtl/gcd_sub.sv
module gcd_sub #(
    parameter int unsigned W = gcd_pkg::GCD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         ack_i,
    output logic         idle_o,
    output logic         done_o,
    output logic [W-1:0] gcd_o
);
    localparam int unsigned NFLAG = 2;

    gcd_pkg::gcd_cmd_s cmd;
    logic [W-1:0]      x_val;
    logic [W-1:0]      y_val;
    logic              lt_raw, yz_raw;
    logic [NFLAG-1:0]  flags_q;

    gcd_dpath #(.W(W)) u_dpath (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .opa    (opa_i),
        .opb    (opb_i),
        .x_val  (x_val),
        .y_val  (y_val),
        .lt_raw (lt_raw),
        .yz_raw (yz_raw)
    );

    gcd_flags #(.NF(NFLAG)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_in  ({yz_raw, lt_raw}),
        .flag_out (flags_q)
    );

    gcd_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_i),
        .ack   (ack_i),
        .lt_q  (flags_q[0]),
        .yz_q  (flags_q[1]),
        .cmd   (cmd),
        .idle  (idle_o),
        .done  (done_o)
    );

    assign gcd_o = x_val;
endmodule

// File: rtl/gcd_sub_chk.sv
module gcd_sub_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         ack_i,
    input logic         idle_o,
    input logic         done_o,
    input logic [W-1:0] gcd_o,
    input logic [W-1:0] y_val
);
    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ack_i) |=> (done_o && $stable(gcd_o)));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ack_i) |=> (idle_o && !done_o));

    // R5
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && start_i) |=> (!idle_o && !done_o));

    // R5
    busy_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && !done_o) |=> !idle_o);

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_o && done_o));

    // R2
    finish_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (y_val == '0));
endmodule

bind gcd_sub gcd_sub_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ack_i   (ack_i),
    .idle_o  (idle_o),
    .done_o  (done_o),
    .gcd_o   (gcd_o),
    .y_val   (y_val)
);

// File: tb/test_gcd_sub.sv
module test_gcd_sub;
    localparam int NV = 15;
    // each entry: {operand a, operand b, expected gcd}
    localparam logic [95:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'h0000_0000, 32'h0000_0009, 32'h0000_0009},
        {32'h0000_0009, 32'h0000_0000, 32'h0000_0009},
        {32'd12,        32'd18,        32'd6},
        {32'd1,         32'd17,        32'd1},
        {32'd35,        32'd64,        32'd1},
        {32'd1,         32'd1,         32'd1},
        {32'd270,       32'd192,       32'd6},
        {32'd1000,      32'd7,         32'd1},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'hFFFF_FFFE, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
        {32'h7FFF_FFFF, 32'hFFFF_FFFE, 32'h7FFF_FFFF},
        {32'hC000_0000, 32'h2000_0000, 32'h2000_0000},
        {32'h1000_0000, 32'hA000_0000, 32'h1000_0000},
        {32'h8000_0000, 32'h4000_0000, 32'h4000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        ack_i = 1'b0;
    logic        idle_o, done_o;
    logic [31:0] gcd_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gcd_sub i_gcd_sub (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .ack_i   (ack_i),
        .idle_o  (idle_o),
        .done_o  (done_o),
        .gcd_o   (gcd_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_gcd(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] t;
        while (b != 0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic int ref_steps(input logic [31:0] a, input logic [31:0] b);
        int n = 0;
        logic [31:0] t;
        forever begin
            n++;
            if (b == 0) break;
            if (a < b) begin
                t = a; a = b; b = t;
            end else begin
                a = a - b;
            end
        end
        return n;
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp_g, input string req);
        int lat = 0;
        int exp_lat;
        exp_lat = 2 * ref_steps(a, b);
        @(negedge clk);
        start_i = 1'b1; opa_i = a; opb_i = b;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && lat < 100000) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        check(done_o && gcd_o == exp_g, req, gcd_o, exp_g);
        // R6: completion edge count
        check(lat == exp_lat, "R6", lat, exp_lat);
        repeat (3) @(negedge clk);
        // R4: result held without acknowledge
        check(done_o && gcd_o == exp_g, "R4", gcd_o, exp_g);
        ack_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack_i = 1'b0;
        // R4 R8: back to idle after acknowledge
        check(idle_o && !done_o, "R4", {idle_o, done_o}, 2'b10);
    endtask

    function automatic string vec_tag(input int i);
        if (i < 3)  return "R3";
        if (i >= 10) return "R7";
        return "R2";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(idle_o && !done_o && gcd_o == 0, "R1", {idle_o, done_o, gcd_o[0]}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle_o && !done_o && gcd_o == 0, "R1", gcd_o, 0);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], vec_tag(i));
        end

        for (int i = 0; i < 24; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom & 32'h3FF;
            rb = $urandom & 32'h3FF;
            run_op(ra, rb, ref_gcd(ra, rb), "R2");
        end

        // R5: start pulse during computation is dropped
        @(negedge clk);
        start_i = 1'b1; opa_i = 32'd12; opb_i = 32'd18;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1; opa_i = 32'd7; opb_i = 32'd7;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(!idle_o, "R8", idle_o, 0);
        for (int k = 0; k < 200 && !done_o; k++) @(negedge clk);
        check(done_o && gcd_o == 32'd6, "R5", gcd_o, 32'd6);

        // R5: start arriving with acknowledge in the result state is dropped
        start_i = 1'b1; ack_i = 1'b1; opa_i = 32'd5; opb_i = 32'd5;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; ack_i = 1'b0;
        check(idle_o && !done_o, "R5", {idle_o, done_o}, 2'b10);
        @(negedge clk);
        check(idle_o && !done_o && gcd_o == 32'd6, "R5", gcd_o, 32'd6);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule